// File: doc/BRIEF.md
# SPI Master with Automatic Per-Word Frame Select

This block is a bus-master SPI engine. Words arrive through a valid/ready input and wait in a small transmit queue. The engine sends them one after another in mode 0: the clock idles low, data is launched on the falling edge and captured on the rising edge, and the most significant bit goes first. The serial clock comes from the system clock through a programmable divider.

The engine drives the active-low frame-select pin by itself. Frame select drops for each word. It goes high again one serial-clock period after the last bit of that word has been captured. When more words are waiting, frame select stays high for exactly one serial-clock period, with the clock held low, and then falls for the next word. A receiver that freezes its shift register while selected therefore sees a fresh frame for every word. The word shifted in on MISO is presented with a one-cycle valid strobe when its frame closes.

Top module: `spi_fss_master`

## Requirements
- R1: While reset is high and in the cycle after it, `fss_n` is 1, `sclk` is 0, `busy` is 0, `rx_valid` is 0 and `in_ready` is 1.
- R2: `sclk` is low whenever the engine is idle. Each frame has exactly 8 rising `sclk` edges. Consecutive rising edges are `2*HALF_DIV` system clocks apart.
- R3: `mosi` carries the accepted word MSB first and is stable at every rising `sclk` edge. The first rising edge comes `HALF_DIV` system clocks after `fss_n` falls.
- R4: MISO is captured on rising `sclk` edges, MSB first. The 8-bit result appears on `rx_data` with `rx_valid` high for one cycle, in the same cycle that `fss_n` rises.
- R5: `fss_n` stays low through all 8 bits of a word. It rises exactly `2*HALF_DIV` system clocks (one serial-clock period) after the last rising `sclk` edge.
- R6: When another word is queued, `fss_n` stays high for exactly `2*HALF_DIV` system clocks between frames. `sclk` is never high while `fss_n` is high.
- R7: `busy` is high whenever `fss_n` is low. With an empty queue, `busy` falls `2*HALF_DIV` system clocks after the final rise of `fss_n`. While `busy` is low, `fss_n` is high.
- R8: The queue holds `QUEUE_DEPTH` words. `in_ready` is low while it is full. Accepted words are transmitted in the order they were accepted, none lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Word offered for transmission |
| in_data | input | WORD_W | Word to transmit |
| in_ready | output | 1 | Queue can accept a word |
| rx_data | output | WORD_W | Word captured from MISO |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| busy | output | 1 | Engine is transferring or in the inter-frame gap |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| fss_n | output | 1 | Frame select, active low |

## Verification
Every serial event is timed in system clocks from the previous one. The first rising edge comes `HALF_DIV` cycles after `fss_n` falls, and later edges come every `2*HALF_DIV` cycles. Both the closing rise of `fss_n` and the fall of `busy` come `2*HALF_DIV` cycles after the event before them. The bench counts clock cycles and samples every pin on the falling system-clock edge. It records the cycle of each transition and compares the differences with these exact figures, so a transition that comes one cycle early or late is reported. The received-word strobe is checked in the same sample that sees `fss_n` rise.

// File: rtl/spi_fss_pkg.sv
package spi_fss_pkg;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_SHIFT = 2'd1,
        ENG_HOLD  = 2'd2,
        ENG_GAP   = 2'd3
    } eng_state_e;

    typedef struct packed {
        logic sclk;
        logic fss_n;
    } line_state_t;

    function automatic int unsigned width_for(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/spi_fss_clkdiv.sv
module spi_fss_clkdiv #(
    parameter int unsigned HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    import spi_fss_pkg::*;

    localparam int unsigned CW = width_for(HALF_DIV);
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == LAST);

    a_r2_div_in_range: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

endmodule

// File: rtl/spi_fss_txq.sv
module spi_fss_txq #(
    parameter int unsigned WORD_W = 8,
    parameter int unsigned DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    output logic              empty
);
    import spi_fss_pkg::*;

    localparam int unsigned PW = width_for(DEPTH);
    localparam int unsigned CNW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] PLAST = PW'(DEPTH - 1);
    localparam logic [CNW-1:0] CFULL = CNW'(DEPTH);

    logic [WORD_W-1:0] mem_q [DEPTH];
    logic [PW-1:0]     wp_q, rp_q;
    logic [CNW-1:0]    cnt_q;
    logic              do_wr;

    assign wr_ready = (cnt_q != CFULL);
    assign empty    = (cnt_q == '0);
    assign do_wr    = wr_valid && wr_ready;
    assign rd_data  = mem_q[rp_q];

    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem_q[wp_q] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_wr) begin
                wp_q <= (wp_q == PLAST) ? '0 : wp_q + 1'b1;
            end
            if (rd_en) begin
                rp_q <= (rp_q == PLAST) ? '0 : rp_q + 1'b1;
            end
            case ({do_wr, rd_en})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CFULL);

    a_r8_no_pop_when_empty: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (cnt_q != '0));

endmodule

// File: rtl/spi_fss_engine.sv
module spi_fss_engine #(
    parameter int unsigned WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              q_empty,
    input  logic [WORD_W-1:0] q_data,
    output logic              q_pop,
    input  logic              miso,
    output logic              sclk,
    output logic              fss_n,
    output logic              mosi,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              active
);
    import spi_fss_pkg::*;

    localparam int unsigned EDGES = 2 * WORD_W;
    localparam int unsigned PHW   = $clog2(EDGES + 1);
    localparam logic [PHW-1:0] PH_LAST = PHW'(EDGES - 1);

    eng_state_e        state_q;
    line_state_t       line_q;
    logic [PHW-1:0]    ph_q;
    logic [WORD_W-1:0] tx_sr_q, rx_sr_q, rx_data_q;
    logic              rx_valid_q;
    logic              load;

    always_comb begin
        load = 1'b0;
        if (!q_empty) begin
            if (state_q == ENG_IDLE) begin
                load = 1'b1;
            end else if (state_q == ENG_GAP && tick && ph_q != '0) begin
                load = 1'b1;
            end
        end
    end

    assign q_pop = load;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ENG_IDLE;
            line_q     <= '{sclk: 1'b0, fss_n: 1'b1};
            ph_q       <= '0;
            tx_sr_q    <= '0;
            rx_sr_q    <= '0;
            rx_data_q  <= '0;
            rx_valid_q <= 1'b0;
        end else begin
            rx_valid_q <= 1'b0;
            if (load) begin
                tx_sr_q      <= q_data;
                line_q.fss_n <= 1'b0;
                ph_q         <= '0;
                state_q      <= ENG_SHIFT;
            end else begin
                case (state_q)
                    ENG_SHIFT: begin
                        if (tick) begin
                            ph_q <= ph_q + 1'b1;
                            if (!line_q.sclk) begin
                                line_q.sclk <= 1'b1;
                                rx_sr_q     <= {rx_sr_q[WORD_W-2:0], miso};
                            end else begin
                                line_q.sclk <= 1'b0;
                                tx_sr_q     <= {tx_sr_q[WORD_W-2:0], 1'b0};
                                if (ph_q == PH_LAST) begin
                                    state_q <= ENG_HOLD;
                                end
                            end
                        end
                    end
                    ENG_HOLD: begin
                        if (tick) begin
                            line_q.fss_n <= 1'b1;
                            rx_data_q    <= rx_sr_q;
                            rx_valid_q   <= 1'b1;
                            ph_q         <= '0;
                            state_q      <= ENG_GAP;
                        end
                    end
                    ENG_GAP: begin
                        if (tick) begin
                            if (ph_q == '0) begin
                                ph_q <= 1;
                            end else begin
                                state_q <= ENG_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sclk     = line_q.sclk;
    assign fss_n    = line_q.fss_n;
    assign mosi     = tx_sr_q[WORD_W-1];
    assign rx_data  = rx_data_q;
    assign rx_valid = rx_valid_q;
    assign active   = (state_q != ENG_IDLE);

    a_r4_strobe_on_fss_rise: assert property (@(posedge clk) disable iff (rst)
        rx_valid_q |-> (line_q.fss_n && !$past(line_q.fss_n)));

    a_r6_clock_low_when_deselected: assert property (@(posedge clk) disable iff (rst)
        line_q.fss_n |-> !line_q.sclk);

    a_r2_clock_moves_on_tick: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(line_q.sclk));

endmodule

// File: rtl/spi_fss_master.sv
module spi_fss_master #(
    parameter int unsigned WORD_W      = 8,
    parameter int unsigned HALF_DIV    = 2,
    parameter int unsigned QUEUE_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              busy,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              fss_n
);

    logic              q_empty, q_pop, tick, active;
    logic [WORD_W-1:0] q_data;

    spi_fss_txq #(.WORD_W(WORD_W), .DEPTH(QUEUE_DEPTH)) u_txq (
        .clk      (clk),
        .rst      (rst),
        .wr_valid (in_valid),
        .wr_data  (in_data),
        .wr_ready (in_ready),
        .rd_en    (q_pop),
        .rd_data  (q_data),
        .empty    (q_empty)
    );

    spi_fss_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (active),
        .tick (tick)
    );

    spi_fss_engine #(.WORD_W(WORD_W)) u_eng (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .q_empty  (q_empty),
        .q_data   (q_data),
        .q_pop    (q_pop),
        .miso     (miso),
        .sclk     (sclk),
        .fss_n    (fss_n),
        .mosi     (mosi),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .active   (active)
    );

    assign busy = active;

    a_r7_idle_deselected: assert property (@(posedge clk) disable iff (rst)
        !busy |-> fss_n);

    a_r7_selected_means_busy: assert property (@(posedge clk) disable iff (rst)
        !fss_n |-> busy);

endmodule

// File: tb/sim_spi_fss_master.sv
module sim_spi_fss_master;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;
    localparam int HALF       = 2;
    localparam int DEPTH      = 4;
    localparam int SCLK_CYC   = 2 * HALF;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_data = '0;
    logic         in_ready;
    logic [W-1:0] rx_data;
    logic         rx_valid;
    logic         busy;
    logic         sclk;
    logic         mosi;
    logic         miso = 1'b0;
    logic         fss_n;

    spi_fss_master #(.WORD_W(W), .HALF_DIV(HALF), .QUEUE_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .rx_data(rx_data), .rx_valid(rx_valid),
        .busy(busy), .sclk(sclk), .mosi(mosi), .miso(miso), .fss_n(fss_n)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_run = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    logic [W-1:0] exp_tx[$];
    logic [W-1:0] exp_rx[$];
    bit saw_full = 0;

    // Driver: offer one word, wait for acceptance, record it as expected.
    task automatic send(input logic [W-1:0] d);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        exp_tx.push_back(d);
        while (!in_ready) begin
            saw_full = 1;
            @(negedge clk);
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy || exp_tx.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Monitor and slave model
    logic         p_fss = 1'b1, p_sclk = 1'b0, p_busy = 1'b0;
    int           t_fall = 0, t_rise = 0, t_last = 0, nbits = 0, frame_no = 0;
    bit           have_rise = 0, gap_valid = 0, first_edge = 0;
    logic [W-1:0] word = '0, reply = '0, rsh = '0;

    always @(negedge clk) begin
        if (!rst) begin
            if (p_fss && !fss_n) begin
                if (have_rise && gap_valid)
                    chk(cyc - t_rise == SCLK_CYC, "R6", "select gap cycles", cyc - t_rise, SCLK_CYC);
                reply = 8'h3C ^ 8'(frame_no * 29);
                frame_no++;
                exp_rx.push_back(reply);
                miso = reply[W-1];
                rsh = reply << 1;
                nbits = 0;
                t_fall = cyc;
                first_edge = 1;
            end
            if (!fss_n && !p_sclk && sclk) begin
                word = {word[W-2:0], mosi};
                nbits++;
                if (first_edge)
                    chk(cyc - t_fall == HALF, "R3", "select to first edge", cyc - t_fall, HALF);
                else
                    chk(cyc - t_last == SCLK_CYC, "R2", "edge spacing", cyc - t_last, SCLK_CYC);
                first_edge = 0;
                t_last = cyc;
            end
            if (!fss_n && p_sclk && !sclk) begin
                miso = rsh[W-1];
                rsh = rsh << 1;
            end
            if (!p_fss && fss_n) begin
                chk(nbits == W, "R2", "rising edges per frame", nbits, W);
                if (exp_tx.size() == 0) begin
                    chk(0, "R8", "unexpected frame", word, 0);
                end else begin
                    logic [W-1:0] e;
                    e = exp_tx.pop_front();
                    chk(word == e, "R3", "word on mosi", word, e);
                end
                chk(cyc - t_last == SCLK_CYC, "R5", "last edge to deselect", cyc - t_last, SCLK_CYC);
                chk(rx_valid == 1'b1, "R4", "strobe with deselect", rx_valid, 1);
                t_rise = cyc;
                have_rise = 1;
                gap_valid = 1;
            end
            if (rx_valid) begin
                if (exp_rx.size() == 0) begin
                    chk(0, "R4", "unexpected strobe", rx_data, 0);
                end else begin
                    logic [W-1:0] e;
                    e = exp_rx.pop_front();
                    chk(rx_data == e, "R4", "received word", rx_data, e);
                end
            end
            if (fss_n && sclk) chk(0, "R6", "clock high while deselected", sclk, 0);
            if (!fss_n && !busy) chk(0, "R7", "busy low while selected", busy, 1);
            if (p_busy && !busy) begin
                chk(cyc - t_rise == SCLK_CYC, "R7", "deselect to busy fall", cyc - t_rise, SCLK_CYC);
                chk(fss_n == 1'b1, "R7", "deselected at idle", fss_n, 1);
                gap_valid = 0;
            end
            p_fss  = fss_n;
            p_sclk = sclk;
            p_busy = busy;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual running expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(fss_n == 1'b1, "R1", "fss_n in reset", fss_n, 1);
        chk(sclk == 1'b0, "R1", "sclk in reset", sclk, 0);
        chk(busy == 1'b0, "R1", "busy in reset", busy, 0);
        chk(rx_valid == 1'b0, "R1", "rx_valid in reset", rx_valid, 0);
        chk(in_ready == 1'b1, "R1", "in_ready in reset", in_ready, 1);
        rst = 1'b0;
        @(negedge clk);
        chk(fss_n == 1'b1 && sclk == 1'b0 && busy == 1'b0, "R1", "idle after reset",
            {fss_n, sclk, busy}, 3'b100);

        // single word
        send(8'hA5);
        wait_idle();

        // short back-to-back burst
        send(8'h81);
        send(8'h7E);
        send(8'h00);
        wait_idle();

        // burst longer than the queue
        for (int i = 0; i < 7; i++) send(8'(8'hF0 + i * 37));
        wait_idle();
        chk(saw_full == 1, "R8", "in_ready dropped when full", saw_full, 1);

        chk(exp_tx.size() == 0, "R8", "words left unsent", exp_tx.size(), 0);
        chk(exp_rx.size() == 0, "R4", "strobes missing", exp_rx.size(), 0);
        chk(frame_no == 11, "R8", "frame count", frame_no, 11);
        chk(fss_n == 1'b1 && sclk == 1'b0 && !busy && in_ready, "R7", "final idle",
            {fss_n, sclk, busy, in_ready}, 4'b1001);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule